// File: doc/BRIEF.md
# Buffered Serial Port Register Core

This block is the host-facing half of a classic byte-oriented asynchronous serial port. A processor reaches its registers over a small bus with a 3-bit offset and separate read and write enables. Behind the registers sit two byte queues, one toward the transmit shifter and one from the receive shifter. Both shifters are outside the block. The transmit shifter takes bytes through a pop port, and the receive shifter delivers bytes through a push port.

After reset the queues act as single-byte holding registers. When the host sets the enable bit in the queue control register, each queue holds up to 16 bytes. The identification register then reports queue mode in its two top bits. The receive interrupt is raised when the receive queue holds at least a host-chosen number of bytes. The transmit interrupt is raised when the transmit queue drains.

A bank bit in the line control register swaps the two lowest offsets over to a 16-bit baud divisor. The divisor and the frame-format bits are driven out to the shifters.

Top module: `uart_fifo_core`

## Requirements
- R1: After reset the identification register (offset 2) reads 0x01, line status (offset 5) reads 0x60 with `txIdle` high, interrupt enable (offset 1) and line control (offset 3) read 0x00, and `irq` is low.
- R2: Offset 7 returns the last byte written to it, and offsets 4 and 6 read 0x00.
- R3: While line control bit 7 is 1, offsets 0 and 1 read and write the divisor low and high bytes, and `divisor` shows {high, low}. Line control reads back as written, and its bits 6:0 drive `lineCfg` (0x03 means 8 data bits, 1 stop bit, no parity).
- R4: Bit 0 of a write to offset 2 turns queue mode on or off. Bits 7:6 of the identification register read 11 when queue mode is on and 00 when it is off. Any change of this bit empties both queues.
- R5: In queue mode each queue holds 16 bytes in arrival order; with queue mode off each holds one byte. A receive push into a full queue is dropped and sets line status bit 1, which a read of line status clears. A host write into a full transmit queue is dropped.
- R6: With interrupt-enable bit 0 set, a receive interrupt (identification 0xC4 in queue mode) is pending while the receive count is at least the trigger level. Bits 7:6 of the queue control write select the level: 00→1, 01→4, 10→8, 11→14. With queue mode off the level is 1.
- R7: With interrupt-enable bit 1 set, a transmit-empty interrupt (identification 0xC2 in queue mode) is raised when the transmit queue becomes empty, or when bit 1 is written while it is empty. A read of the identification register that reports it clears it, and so does a write to offset 0. The receive interrupt takes precedence.
- R8: With interrupt enable 0x00, `irq` stays low and identification bit 0 reads 1 whatever the queues hold.
- R9: Bit 1 of a write to offset 2 empties only the receive queue, and bit 2 empties only the transmit queue.
- R10: Line status bit 0 is 1 while receive data is held. Bit 5 is 1 while the transmit queue is empty. Bit 6 is 1 while the transmit queue is empty and `txIdle` is high.
- R11: `txAvail` is high while the transmit queue holds a byte, and `txByte` shows the oldest byte. A `txPop` pulse removes that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register offset |
| busWrEn | input | 1 | Write strobe, one cycle per access |
| busWrData | input | 8 | Write data |
| busRdEn | input | 1 | Read strobe, one cycle per access; read side effects apply at the clock edge |
| busRdData | output | 8 | Read data, valid combinationally while busRdEn is high |
| irq | output | 1 | Interrupt level, high while an enabled condition is pending |
| txIdle | input | 1 | Transmit shifter has no frame in progress |
| txPop | input | 1 | Transmit shifter takes the head byte |
| txAvail | output | 1 | Transmit queue not empty |
| txByte | output | 8 | Head of the transmit queue |
| rxPush | input | 1 | Receive shifter delivers a byte |
| rxByte | input | 8 | Received byte |
| divisor | output | 16 | Baud divisor |
| lineCfg | output | 7 | Frame-format bits of line control |

## Verification
The bench runs all four trigger levels. For each level it fills the receive queue from 1 to 16 bytes and then drains it, checking `irq` after every step. An off-by-one in the level compare would move the interrupt edge by one byte, and a wrong level table would move it by several. It pushes a seventeenth byte and also overfills the single-byte mode. A queue that wraps instead of dropping would return corrupted order or miss the overrun flag. It checks that the transmit-empty interrupt is cleared by the identification read and that receive data overrides it, and that each queue clear leaves the other queue intact.

// File: rtl/uart_core_pkg.sv
package uart_core_pkg;
  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic txClr;
    logic rxClr;
    logic singleMode;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    IID_NONE = 3'b000,
    IID_TXE  = 3'b001,
    IID_RXD  = 3'b010
  } iidCode_t;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IEN  = 3'd1;
  localparam logic [2:0] OFS_IDQC = 3'd2;
  localparam logic [2:0] OFS_LCTL = 3'd3;
  localparam logic [2:0] OFS_LSTA = 3'd5;
  localparam logic [2:0] OFS_SCR  = 3'd7;
endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             single,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic             dropped
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic full, doPush, doPop;

  assign full    = single ? (count != '0) : (count == CW'(DEPTH));
  assign doPop   = pop && (count != '0);
  assign doPush  = push && (!full || doPop);
  assign dropped = push && !doPush && !clr;
  assign head    = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !clr) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  a_r5_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop && !clr) |=> $stable(count));
endmodule

// File: rtl/uart_core_data.sv
module uart_core_data
  import uart_core_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [WIDTH-1:0] wrData,
  input  logic             txPop,
  input  logic             rxPush,
  input  logic [WIDTH-1:0] rxByte,
  output logic [WIDTH-1:0] txHead,
  output logic [WIDTH-1:0] rxHead,
  output logic [$clog2(DEPTH+1)-1:0] txCount,
  output logic [$clog2(DEPTH+1)-1:0] rxCount,
  output logic             rxDrop
);
  logic txDropUnused;

  uart_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_txq (
    .clk(clk), .rstN(rstN), .clr(strobe.txClr), .single(strobe.singleMode),
    .push(strobe.txPush), .pushData(wrData), .pop(txPop),
    .head(txHead), .count(txCount), .dropped(txDropUnused));

  uart_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_rxq (
    .clk(clk), .rstN(rstN), .clr(strobe.rxClr), .single(strobe.singleMode),
    .push(rxPush), .pushData(rxByte), .pop(strobe.rxPop),
    .head(rxHead), .count(rxCount), .dropped(rxDrop));

  a_r9_rx_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rxClr |=> (rxCount == '0));
  a_r9_tx_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txClr |=> (txCount == '0));
  a_r5_single_depth: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.singleMode && $past(strobe.singleMode)) |-> (rxCount <= 1));
endmodule

// File: rtl/uart_reg_ctrl.sv
module uart_reg_ctrl
  import uart_core_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       busAddr,
  input  logic             busWrEn,
  input  logic [WIDTH-1:0] busWrData,
  input  logic             busRdEn,
  output logic [WIDTH-1:0] busRdData,
  input  logic             txIdle,
  input  logic [$clog2(DEPTH+1)-1:0] txCount,
  input  logic [$clog2(DEPTH+1)-1:0] rxCount,
  input  logic [WIDTH-1:0] rxHead,
  input  logic             rxDrop,
  output dpStrobe_t        strobe,
  output logic             irq,
  output logic [2*WIDTH-1:0] divisor,
  output logic [6:0]       lineCfg
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] LVL0 = CW'(1);
  localparam logic [CW-1:0] LVL1 = CW'(DEPTH/4);
  localparam logic [CW-1:0] LVL2 = CW'(DEPTH/2);
  localparam logic [CW-1:0] LVL3 = CW'(DEPTH-2);

  logic [1:0] ienReg, trigSel;
  logic [7:0] lctlReg, scrReg, divLo, divHi;
  logic fifoOn, txPend, overrun, prevTxEmpty;
  logic dlab, qcWr, enChange, idRd, lsRd, ienWr;
  logic txEmpty, rxHit, rxInt, txInt, txSet, txClrPend;
  logic [CW-1:0] rxLevel;
  iidCode_t iid;

  assign dlab     = lctlReg[7];
  assign qcWr     = busWrEn && busAddr == OFS_IDQC;
  assign enChange = qcWr && (busWrData[0] != fifoOn);
  assign idRd     = busRdEn && busAddr == OFS_IDQC;
  assign lsRd     = busRdEn && busAddr == OFS_LSTA;
  assign ienWr    = busWrEn && busAddr == OFS_IEN && !dlab;

  assign strobe.txPush     = busWrEn && busAddr == OFS_DATA && !dlab;
  assign strobe.rxPop      = busRdEn && busAddr == OFS_DATA && !dlab;
  assign strobe.rxClr      = qcWr && (busWrData[1] || enChange);
  assign strobe.txClr      = qcWr && (busWrData[2] || enChange);
  assign strobe.singleMode = !fifoOn;

  always_comb begin
    case (trigSel)
      2'd0:    rxLevel = LVL0;
      2'd1:    rxLevel = LVL1;
      2'd2:    rxLevel = LVL2;
      default: rxLevel = LVL3;
    endcase
    if (!fifoOn) rxLevel = LVL0;
  end

  assign txEmpty = (txCount == '0);
  assign rxHit   = rxCount >= rxLevel;
  assign rxInt   = ienReg[0] && rxHit;
  assign txInt   = ienReg[1] && txPend;
  assign iid     = rxInt ? IID_RXD : (txInt ? IID_TXE : IID_NONE);
  assign irq     = rxInt || txInt;

  assign txSet     = (txEmpty && !prevTxEmpty) || (ienWr && busWrData[1] && txEmpty);
  assign txClrPend = strobe.txPush || (idRd && iid == IID_TXE);

  always_comb begin
    busRdData = '0;
    case (busAddr)
      OFS_DATA: busRdData = dlab ? divLo : rxHead;
      OFS_IEN:  busRdData = dlab ? divHi : {6'b0, ienReg};
      OFS_IDQC: busRdData = {fifoOn, fifoOn, 2'b00, iid, !irq};
      OFS_LCTL: busRdData = lctlReg;
      OFS_LSTA: busRdData = {1'b0, txEmpty && txIdle, txEmpty, 3'b000,
                             overrun, rxCount != '0};
      OFS_SCR:  busRdData = scrReg;
      default:  busRdData = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ienReg <= '0; trigSel <= '0; lctlReg <= '0; scrReg <= '0;
      divLo <= '0; divHi <= '0; fifoOn <= 1'b0; txPend <= 1'b0;
      overrun <= 1'b0; prevTxEmpty <= 1'b1;
    end else begin
      prevTxEmpty <= txEmpty;
      if (busWrEn) begin
        case (busAddr)
          OFS_DATA: if (dlab) divLo <= busWrData;
          OFS_IEN:  if (dlab) divHi <= busWrData; else ienReg <= busWrData[1:0];
          OFS_IDQC: begin fifoOn <= busWrData[0]; trigSel <= busWrData[7:6]; end
          OFS_LCTL: lctlReg <= busWrData;
          OFS_SCR:  scrReg <= busWrData;
          default:  ;
        endcase
      end
      if (txSet)          txPend <= 1'b1;
      else if (txClrPend) txPend <= 1'b0;
      if (rxDrop)         overrun <= 1'b1;
      else if (lsRd)      overrun <= 1'b0;
    end
  end

  assign divisor = {divHi, divLo};
  assign lineCfg = lctlReg[6:0];

  a_r8_ien_masks: assert property (@(posedge clk) disable iff (!rstN)
    (ienReg == 2'b00) |-> !irq);
  a_r4_toggle_flushes: assert property (@(posedge clk) disable iff (!rstN)
    enChange |=> (rxCount == '0 && txCount == '0));
  a_r7_thr_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.txPush && !txEmpty) |=> !txPend);
endmodule

// File: rtl/uart_fifo_core.sv
module uart_fifo_core
  import uart_core_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       busAddr,
  input  logic             busWrEn,
  input  logic [WIDTH-1:0] busWrData,
  input  logic             busRdEn,
  output logic [WIDTH-1:0] busRdData,
  output logic             irq,
  input  logic             txIdle,
  input  logic             txPop,
  output logic             txAvail,
  output logic [WIDTH-1:0] txByte,
  input  logic             rxPush,
  input  logic [WIDTH-1:0] rxByte,
  output logic [2*WIDTH-1:0] divisor,
  output logic [6:0]       lineCfg
);
  localparam int CW = $clog2(DEPTH+1);

  dpStrobe_t strobe;
  logic [CW-1:0] txCount, rxCount;
  logic [WIDTH-1:0] rxHead;
  logic rxDrop;

  uart_reg_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .txIdle(txIdle), .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead),
    .rxDrop(rxDrop), .strobe(strobe), .irq(irq), .divisor(divisor),
    .lineCfg(lineCfg));

  uart_core_data #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWrData),
    .txPop(txPop), .rxPush(rxPush), .rxByte(rxByte), .txHead(txByte),
    .rxHead(rxHead), .txCount(txCount), .rxCount(rxCount), .rxDrop(rxDrop));

  assign txAvail = (txCount != '0);
endmodule

// File: tb/test_uart_fifo_core.sv
module test_uart_fifo_core;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic busWrEn = 1'b0, busRdEn = 1'b0, txIdle = 1'b1, txPop = 1'b0, rxPush = 1'b0;
  logic [7:0] busWrData = '0, rxByte = '0;
  logic [7:0] busRdData, txByte;
  logic irq, txAvail;
  logic [15:0] divisor;
  logic [6:0] lineCfg;
  logic [7:0] rd;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_fifo_core i_uart_fifo_core (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .irq(irq), .txIdle(txIdle), .txPop(txPop), .txAvail(txAvail),
    .txByte(txByte), .rxPush(rxPush), .rxByte(rxByte), .divisor(divisor),
    .lineCfg(lineCfg));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a);
    @(negedge clk); busAddr = a; busRdEn = 1'b1;
    #1 rd = busRdData;
    @(negedge clk); busRdEn = 1'b0;
  endtask

  task automatic pushRx(input logic [7:0] d);
    @(negedge clk); rxByte = d; rxPush = 1'b1;
    @(negedge clk); rxPush = 1'b0;
  endtask

  task automatic popTx();
    @(negedge clk); txPop = 1'b1;
    @(negedge clk); txPop = 1'b0;
  endtask

  function automatic int levelOf(input int sel);
    case (sel)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rdReg(3'd2); check("R1 ident", rd, 8'h01);
    rdReg(3'd5); check("R1 lstat", rd, 8'h60);
    rdReg(3'd1); check("R1 ien", rd, 8'h00);
    rdReg(3'd3); check("R1 lctl", rd, 8'h00);
    check("R1 irq", irq, 0);

    // R2 scratch sweep
    for (int v = 0; v < 256; v += 17) begin
      wr(3'd7, 8'(v)); rdReg(3'd7); check("R2 scratch", rd, v);
    end
    wr(3'd7, 8'hAA); rdReg(3'd7); check("R2 scratch AA", rd, 8'hAA);
    rdReg(3'd4); check("R2 ofs4", rd, 0);
    rdReg(3'd6); check("R2 ofs6", rd, 0);

    // R3 divisor bank and line control
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h30); wr(3'd1, 8'h00);
    check("R3 divisor 2400", divisor, 16'h0030);
    wr(3'd0, 8'h34); wr(3'd1, 8'h12);
    rdReg(3'd0); check("R3 div lo", rd, 8'h34);
    rdReg(3'd1); check("R3 div hi", rd, 8'h12);
    check("R3 divisor", divisor, 16'h1234);
    wr(3'd3, 8'h03);
    rdReg(3'd3); check("R3 lctl", rd, 8'h03);
    check("R3 lineCfg", lineCfg, 7'h03);
    rdReg(3'd1); check("R3 ien untouched", rd, 8'h00);
    check("R3 tx untouched", txAvail, 0);

    // R8 masked, R5 single-byte mode with overrun
    wr(3'd1, 8'h00);
    pushRx(8'h5A);
    check("R8 irq masked", irq, 0);
    rdReg(3'd2); check("R8 ident none", rd, 8'h01);
    pushRx(8'h77);
    rdReg(3'd5); check("R5 single overrun", rd, 8'h63);
    rdReg(3'd5); check("R5 overrun cleared", rd, 8'h61);
    rdReg(3'd0); check("R5 single keeps first", rd, 8'h5A);
    rdReg(3'd5); check("R10 rx drained", rd, 8'h60);

    // R4 queue mode ident and flush on toggle
    wr(3'd2, 8'h01);
    rdReg(3'd2); check("R4 ident on", rd, 8'hC1);
    pushRx(8'h11); pushRx(8'h22); pushRx(8'h33);
    rdReg(3'd5); check("R10 rx held", rd, 8'h61);
    wr(3'd2, 8'h00);
    rdReg(3'd5); check("R4 flush off", rd, 8'h60);
    rdReg(3'd2); check("R4 ident off", rd, 8'h01);

    // R6 trigger sweep, R5 depth and order, R9 rx clear
    wr(3'd1, 8'h01);
    for (int sel = 0; sel < 4; sel++) begin
      int lvl;
      lvl = levelOf(sel);
      wr(3'd2, 8'(sel << 6) | 8'h03);
      for (int k = 1; k <= 16; k++) begin
        pushRx(8'((sel * 16 + k * 5) & 255));
        check("R6 irq rising", irq, (k >= lvl) ? 1 : 0);
        if (k == lvl) begin
          rdReg(3'd2); check("R6 ident rx", rd, 8'hC4);
        end
      end
      for (int k = 1; k <= 16; k++) begin
        rdReg(3'd0); check("R5 order", rd, (sel * 16 + k * 5) & 255);
        check("R6 irq falling", irq, ((16 - k) >= lvl) ? 1 : 0);
      end
      for (int k = 0; k < 17; k++) pushRx(8'(k));
      rdReg(3'd5); check("R5 deep overrun", rd, 8'h63);
      rdReg(3'd0); check("R5 oldest kept", rd, 0);
      wr(3'd2, 8'(sel << 6) | 8'h03);
      rdReg(3'd5); check("R9 rx cleared", rd, 8'h60);
    end

    // R7 transmit empty interrupt
    wr(3'd2, 8'h01);
    wr(3'd1, 8'h02);
    check("R7 enable while empty", irq, 1);
    rdReg(3'd2); check("R7 ident tx", rd, 8'hC2);
    check("R7 cleared by ident read", irq, 0);
    rdReg(3'd2); check("R7 ident none", rd, 8'hC1);
    for (int k = 0; k < 17; k++) wr(3'd0, 8'(8'hA0 + k));
    rdReg(3'd5); check("R10 tx busy", rd, 8'h00);
    check("R11 avail", txAvail, 1);
    for (int k = 0; k < 16; k++) begin
      check("R11 head order", txByte, 8'hA0 + k);
      popTx();
    end
    check("R5 tx 17th dropped", txAvail, 0);
    @(negedge clk);
    check("R7 raised on drain", irq, 1);
    wr(3'd1, 8'h03);
    pushRx(8'h42);
    rdReg(3'd2); check("R7 rx precedence", rd, 8'hC4);
    rdReg(3'd0); check("R7 rx byte", rd, 8'h42);
    rdReg(3'd2); check("R7 tx after rx", rd, 8'hC2);
    check("R7 irq after ident", irq, 0);
    wr(3'd0, 8'h01); popTx(); @(negedge clk);
    check("R7 rearm", irq, 1);
    wr(3'd0, 8'h02);
    check("R7 cleared by write", irq, 0);

    // R10 idle bit, R9 tx-only clear
    txIdle = 1'b0;
    popTx();
    rdReg(3'd5); check("R10 shifter busy", rd, 8'h20);
    txIdle = 1'b1;
    wr(3'd1, 8'h00);
    pushRx(8'h99);
    for (int k = 0; k < 5; k++) wr(3'd0, 8'(k));
    wr(3'd2, 8'h05);
    check("R9 tx cleared", txAvail, 0);
    rdReg(3'd5); check("R9 rx kept", rd, 8'h61);
    rdReg(3'd0); check("R9 rx byte kept", rd, 8'h99);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule